// File: doc/BRIEF.md
# Zero-Crossing Aligned Amplitude Modulator

This block produces a digitally amplitude-modulated sine carrier for an external DAC. A phase accumulator, stepped by a programmable tuning word, drives a quarter-wave sine table. Each carrier sample is scaled by an amplitude byte that arrives on a valid/ready symbol stream. The scaled product is registered and sent out as a signed DAC word.

A new amplitude is applied only where the carrier crosses zero, so the output never has a step in the middle of a half-cycle. In single-symbol mode one byte covers a whole number of carrier periods. In dual-symbol mode each half-cycle takes its own byte: the positive half uses one byte and the negative half uses the next. If a byte is due but none is offered, the last amplitude is kept and a sticky flag records the shortfall.

Back-pressure rules for the symbol stream: the block raises `sym_ready` for exactly one cycle at each symbol slot, and a byte is consumed only on a cycle where both `sym_valid` and `sym_ready` are high. The source may hold `sym_valid` high for as long as it likes. It must keep `sym_data` stable until the byte is taken. The block never stalls the carrier while waiting for data.

Top module: `zc_am_mod`

## Requirements
- R1: While `rst` is high, `dac_out` is 0, `underrun` is 0 and `sym_ready` is 0.
- R2: Each output word equals (S·A) >>> AMP_W, cut to SAMP_W bits. A is the current unsigned amplitude, and the shift is arithmetic, rounding toward minus infinity. S is sign·round((2^(SAMP_W-1)−1)·|sin(2π·p/2^PHASE_W)|) for a phase p on the table grid (a multiple of 2^(PHASE_W−2−LUT_AW)). S is 0 at phases 0 and 2^(PHASE_W−1), +max at a quarter period and −max at three quarters.
- R3: The phase is 0 in the first cycle after reset and then advances by the tuning word every cycle. The first clock edge with reset low registers the sample for phase 0, and every later edge registers the next phase step, giving one cycle of latency.
- R4: A crossing is a cycle in which the phase MSB differs from its value in the previous cycle. The first cycle after reset counts as a rising crossing. The amplitude changes only at a crossing.
- R5: `sym_ready` is high only in a crossing cycle that is a symbol slot, and only for that one cycle. A byte is consumed when `sym_valid` and `sym_ready` are both high.
- R6: With `dual_mode`=0, slots fall only on rising crossings (MSB 1→0), once every P carrier periods. P is `sym_periods`, read at the slot, and 0 counts as 1.
- R7: With `dual_mode`=1, every crossing is a slot, so positive and negative half-cycles carry successive bytes.
- R8: At a slot with `sym_valid` low, the amplitude is kept. If a byte has been accepted since reset, `underrun` goes to 1 from the next cycle and stays at 1 until reset.
- R9: Until the first byte is accepted after reset, `dac_out` stays at 0.
- R10: The tuning word is sampled only in crossing cycles. The step out of a crossing cycle already uses the new word, and later steps keep that word until the next crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | PHASE_W | Phase step per cycle, sampled at crossings |
| dual_mode | input | 1 | 0: one byte per P periods, 1: one byte per half-cycle |
| sym_periods | input | CNT_W | Carrier periods per byte in single mode (0 means 1) |
| sym_data | input | AMP_W | Amplitude byte |
| sym_valid | input | 1 | Byte offered |
| sym_ready | output | 1 | Byte taken this cycle if valid |
| dac_out | output | SAMP_W | Signed modulated sample |
| underrun | output | 1 | Sticky: a slot passed with no byte |

## Verification
A corrupted phase or tuning register shows up on the very next registered sample, because every output word is a fixed function of the phase and the amplitude. The checks therefore compare every sample of whole carrier periods against the expected values. A wrongly latched amplitude shows at the next nonzero sample of that half-cycle. A faulty period counter or crossing detector shows as a `sym_ready` pulse in the wrong cycle within one symbol period. A lost hold shows as a changed peak after a starved slot.

// File: rtl/zcam_pkg.sv
package zcam_pkg;
  // crossing information produced by the phase stage
  typedef struct packed {
    logic hit;     // phase MSB changed relative to previous cycle
    logic rising;  // change was 1 -> 0 (start of a positive half)
  } zc_t;
endpackage

// File: rtl/zcam_phase.sv
module zcam_phase
  import zcam_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tune_in,
  output logic [PHASE_W-1:0] phase,
  output zc_t                zc
);
  localparam int MSB = PHASE_W - 1;

  logic [MSB:0] ph_q, tune_q, step;
  logic         msb_prev_q;

  always_comb begin
    zc.hit    = ph_q[MSB] ^ msb_prev_q;
    zc.rising = zc.hit & ~ph_q[MSB];
    // the step leaving a crossing already uses the fresh tuning word
    step      = zc.hit ? tune_in : tune_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= '0;
      msb_prev_q <= 1'b1;   // first cycle after reset is a rising crossing
      tune_q     <= '0;
    end else begin
      ph_q       <= ph_q + step;
      msb_prev_q <= ph_q[MSB];
      if (zc.hit) tune_q <= tune_in;
    end
  end

  assign phase = ph_q;

  // R10
  tune_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !zc.hit |=> (tune_q == $past(tune_q)));
endmodule

// File: rtl/zcam_sine.sv
module zcam_sine #(
  parameter int LUT_AW = 6,
  parameter int SAMP_W = 8
) (
  input  logic [LUT_AW+1:0]        ph_top,   // quadrant bits + quarter index
  output logic signed [SAMP_W-1:0] samp
);
  localparam int N    = 1 << LUT_AW;
  localparam int MAXV = (1 << (SAMP_W - 1)) - 1;

  logic [SAMP_W-1:0] lut [0:N];

  generate
    for (genvar g = 0; g <= N; g++) begin : g_ent
      localparam real ANG = 1.5707963267948966 * real'(g) / real'(N);
      localparam int  VAL = $rtoi(real'(MAXV) * $sin(ANG) + 0.5);
      assign lut[g] = SAMP_W'(VAL);
    end
  endgenerate

  logic [1:0]        quad;
  logic [LUT_AW-1:0] qidx;
  logic [LUT_AW:0]   idx;
  logic [SAMP_W-1:0] mag;

  always_comb begin
    quad = ph_top[LUT_AW+1 -: 2];
    qidx = ph_top[LUT_AW-1:0];
    idx  = quad[0] ? ((LUT_AW+1)'(N) - {1'b0, qidx}) : {1'b0, qidx};
    mag  = lut[idx];
    samp = quad[1] ? -$signed(mag) : $signed(mag);
  end

  always_comb begin
    // R2
    if (!quad[1]) begin
      pos_half_sign_chk: assert (!samp[SAMP_W-1]);
    end
  end
endmodule

// File: rtl/zcam_slot.sv
module zcam_slot
  import zcam_pkg::*;
#(
  parameter int AMP_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  zc_t              zc,
  input  logic             dual_in,
  input  logic [CNT_W-1:0] periods_in,
  input  logic [AMP_W-1:0] sym_data,
  input  logic             sym_valid,
  output logic             sym_ready,
  output logic [AMP_W-1:0] amp,
  output logic             underrun,
  output logic             started
);
  logic [CNT_W-1:0] cnt_q;
  logic [AMP_W-1:0] amp_q;
  logic             under_q, started_q, slot, take;

  always_comb begin
    slot = !rst && zc.hit && (dual_in || (zc.rising && cnt_q == '0));
    take = slot && sym_valid;
    // a byte taken at the crossing already scales the crossing sample
    amp  = take ? sym_data : amp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      amp_q     <= '0;
      under_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (take) begin
        amp_q     <= sym_data;
        started_q <= 1'b1;
      end
      if (slot && !sym_valid && started_q) under_q <= 1'b1;
      if (zc.hit) begin
        if (dual_in)
          cnt_q <= '0;
        else if (zc.rising)
          cnt_q <= (cnt_q != '0)      ? cnt_q - 1'b1 :
                   (periods_in == '0) ? '0 : periods_in - 1'b1;
      end
    end
  end

  assign sym_ready = slot;
  assign underrun  = under_q;
  assign started   = started_q;

  // R5
  ready_at_zc_chk: assert property (@(posedge clk) disable iff (rst)
    sym_ready |-> zc.hit);
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  // R4
  amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !zc.hit |=> (amp_q == $past(amp_q)));
endmodule

// File: rtl/zc_am_mod.sv
module zc_am_mod
  import zcam_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 6,
  parameter int SAMP_W  = 8,
  parameter int AMP_W   = 8,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       tune_word,
  input  logic                     dual_mode,
  input  logic [CNT_W-1:0]         sym_periods,
  input  logic [AMP_W-1:0]         sym_data,
  input  logic                     sym_valid,
  output logic                     sym_ready,
  output logic signed [SAMP_W-1:0] dac_out,
  output logic                     underrun
);
  localparam int PROD_W = SAMP_W + AMP_W + 1;
  localparam int TOP_W  = LUT_AW + 2;

  logic [PHASE_W-1:0]       phase;
  zc_t                      zc;
  logic signed [SAMP_W-1:0] samp;
  logic [AMP_W-1:0]         amp;
  logic                     started;
  logic signed [PROD_W-1:0] prod, scaled;

  zcam_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .tune_in(tune_word), .phase(phase), .zc(zc)
  );

  zcam_sine #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_sine (
    .ph_top(phase[PHASE_W-1 -: TOP_W]), .samp(samp)
  );

  zcam_slot #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst(rst), .zc(zc), .dual_in(dual_mode),
    .periods_in(sym_periods), .sym_data(sym_data), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .amp(amp), .underrun(underrun), .started(started)
  );

  always_comb begin
    prod   = PROD_W'(samp) * $signed({1'b0, amp});
    scaled = prod >>> AMP_W;
  end

  always_ff @(posedge clk) begin
    if (rst) dac_out <= '0;
    else     dac_out <= scaled[SAMP_W-1:0];
  end

  // R9
  silent_until_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!started && !(sym_valid && sym_ready)) |=> (dac_out == '0));
endmodule

// File: tb/zc_am_mod_test.sv
module zc_am_mod_test;
  localparam int CLK_P = 10;
  localparam longint T26 = 64'd1 << 26;
  localparam longint T27 = 64'd1 << 27;
  // amplitude byte, expected positive peak
  localparam int VEC [0:5][0:1] = '{'{255,126}, '{128,63}, '{0,0},
                                    '{1,0}, '{64,31}, '{200,99}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tune_word = '0;
  logic        dual_mode = 1'b0;
  logic [7:0]  sym_periods = '0;
  logic [7:0]  sym_data;
  logic        sym_valid, sym_ready, underrun;
  logic signed [7:0] dac_out;

  logic [7:0] mem [0:15];
  int src_n = 0, src_idx = 0, cur = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  assign sym_valid = !rst && (src_idx < src_n);
  assign sym_data  = mem[src_idx[3:0]];

  always @(posedge clk) begin
    if (rst) src_idx <= 0;
    else if (sym_valid && sym_ready) src_idx <= src_idx + 1;
  end

  zc_am_mod uut (
    .clk(clk), .rst(rst), .tune_word(tune_word), .dual_mode(dual_mode),
    .sym_periods(sym_periods), .sym_data(sym_data), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .dac_out(dac_out), .underrun(underrun)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (sample %0d)", req, act, exp, cur);
    end
  endtask

  function automatic int sine_at(longint ph);
    real a, s;
    int  m;
    a = 2.0 * 3.14159265358979 * real'(ph) / 4294967296.0;
    s = $sin(a);
    m = $rtoi((s < 0.0 ? -s : s) * 127.0 + 0.5);
    return (s < 0.0) ? -m : m;
  endfunction

  function automatic int expv(longint ph, int a);
    return (sine_at(ph & 64'hFFFF_FFFF) * a) >>> 8;
  endfunction

  task automatic to_sample(int n);
    if (n > cur) begin
      repeat (n - cur) @(posedge clk);
      #1;
      cur = n;
    end
  endtask

  task automatic start(longint tune, bit dual, int per, int cnt);
    rst = 1'b1;
    tune_word = tune[31:0];
    dual_mode = dual;
    sym_periods = per[7:0];
    src_n = cnt;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dac", int'(dac_out), 0);
    chk("R1 underrun", int'(underrun), 0);
    chk("R1 ready", int'(sym_ready), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1;
    cur = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // vector table: single mode, one byte per period
    for (int j = 0; j < 6; j++) mem[j] = VEC[j][0][7:0];
    start(T26, 1'b0, 1, 6);
    for (int n = 0; n < 384; n++) begin
      to_sample(n);
      chk("R2 R3 sample", int'(dac_out), expv(n * T26, VEC[n/64][0]));
      chk("R5 ready pulse", int'(sym_ready), int'((n % 64) == 63));
      if ((n % 64) == 16) chk("R6 peak", int'(dac_out), VEC[n/64][1]);
      if ((n % 64) == 48) chk("R6 trough", int'(dac_out), expv(48 * T26, VEC[n/64][0]));
    end
    chk("R8 no underrun yet", int'(underrun), 0);
    to_sample(384);
    chk("R8 underrun set", int'(underrun), 1);
    to_sample(400);
    chk("R8 amplitude held", int'(dac_out), VEC[5][1]);
    to_sample(430);
    chk("R8 underrun sticky", int'(underrun), 1);

    // dual mode: one byte per half-cycle
    mem[0] = 8'd200; mem[1] = 8'd60; mem[2] = 8'd255; mem[3] = 8'd10;
    start(T26, 1'b1, 0, 4);
    for (int n = 0; n < 128; n++) begin
      to_sample(n);
      chk("R7 half sample", int'(dac_out), expv(n * T26, int'(mem[n/32])));
      chk("R7 ready pulse", int'(sym_ready), int'((n % 32) == 31));
    end

    // single mode, three periods per byte
    mem[0] = 8'd90; mem[1] = 8'd180;
    start(T26, 1'b0, 3, 2);
    to_sample(16);  chk("R6 p0", int'(dac_out), expv(16 * T26, 90));
    to_sample(63);  chk("R6 no slot", int'(sym_ready), 0);
    to_sample(80);  chk("R6 p1", int'(dac_out), expv(16 * T26, 90));
    to_sample(127); chk("R6 no slot", int'(sym_ready), 0);
    to_sample(144); chk("R6 p2", int'(dac_out), expv(16 * T26, 90));
    to_sample(191); chk("R6 slot", int'(sym_ready), 1);
    to_sample(208); chk("R6 next byte", int'(dac_out), expv(16 * T26, 180));

    // silence before first byte, late arrival, then starvation
    start(T26, 1'b0, 1, 0);
    for (int n = 0; n < 100; n += 3) begin
      to_sample(n);
      chk("R9 silent", int'(dac_out), 0);
    end
    to_sample(100);
    chk("R8 no flag before first byte", int'(underrun), 0);
    mem[0] = 8'd150;
    src_n = 1;
    to_sample(127); chk("R5 ready at crossing", int'(sym_ready), 1);
    to_sample(144); chk("R9 first byte", int'(dac_out), expv(16 * T26, 150));
    to_sample(191); chk("R8 flag clear", int'(underrun), 0);
    to_sample(192); chk("R8 flag set", int'(underrun), 1);
    to_sample(208); chk("R8 held peak", int'(dac_out), expv(16 * T26, 150));

    // tuning word change mid half-cycle
    mem[0] = 8'd255;
    start(T26, 1'b0, 1, 1);
    to_sample(10);
    tune_word = T27[31:0];
    for (int n = 11; n < 48; n++) begin
      to_sample(n);
      if (n <= 32) chk("R10 old step", int'(dac_out), expv(n * T26, 255));
      else chk("R10 new step", int'(dac_out), expv(64'h8000_0000 + (n - 32) * T27, 255));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule